// File: doc/BRIEF.md
# Virtual-Channel Interrupt Aggregator

This block gathers event strobes from four virtual channels of a serial display link, plus the error lines of the link's physical layer, into one registered interrupt for the link engine. That interrupt is then ORed with an interrupt coming from the display controller, which gives a single interrupt for the whole display subsystem.

Each channel has eight event inputs. An event is latched into a sticky per-channel flag register, but only while that channel is switched on. A per-channel mask register chooses which latched flags count as pending. A global status word has one pending bit per channel, and the error bit for the physical layer sits just above those bits. A global enable word selects which of these sources reach the interrupt. The physical-layer error event is taken from five 5-bit groups. Four of the groups are sampled as levels. The escape-error group is edge-detected. Software clears flags by writing ones through a simple synchronous register port. Reads are combinational from the current address.

Top module: `vc_irq_merge`

Register map (word addresses, 4-bit address). 0 holds the channel on bits, with bit c for channel c. 1 holds the interrupt enables: bits 3:0 for the channels and bit 4 for physical-layer errors. 2 is the global status: bits 3:0 are the channel pending bits (read-only) and bit 4 is the physical-layer flag, cleared by writing 1. 4+c is the event mask of channel c, 8 bits. 8+c is the event flag register of channel c, cleared by writing 1. All other bits and addresses read as zero.

## Requirements
- R1: After reset every register reads zero and both `link_irq` and `subsys_irq` are low while `disp_irq` is low.
- R2: A high bit on `vc_evt[8*c+b]` during a clock edge sets flag bit b at address 8+c after that edge only if bit c at address 0 is set. Otherwise the flag stays clear and no interrupt follows.
- R3: Flag bits stay set until a write to their flag address with a 1 in that bit position. Writing 0 leaves a flag unchanged.
- R4: When an event and a clearing write hit the same flag bit in the same cycle, the bit ends up set. Other bits in the same write are still cleared.
- R5: Global status bit c (address 2) reads 1 exactly when channel c has at least one flag bit that is set and also set in its mask at address 4+c.
- R6: `link_irq` is a register. It is high one cycle after any global status bit c is set together with enable bit c at address 1, or after the physical-layer flag is set together with enable bit 4. It drops one cycle after the last such cause goes away.
- R7: While enable bit 4 is set, any high bit in `phy_sync_err`, `phy_ctrl_err`, `phy_lp0_cont` or `phy_lp1_cont` at a clock edge sets status bit 4. While enable bit 4 is clear, these errors leave status bit 4 clear.
- R8: For `phy_esc_err`, only a 0-to-1 change of any bit sets status bit 4. A bit that is held high does not set the flag again after it has been cleared.
- R9: `subsys_irq` is the OR of `link_irq` and `disp_irq`.
- R10: Addresses 0, 1 and 4..7 read back the bits last written to them, limited to their widths (4, 5 and 8 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address (read and write) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| vc_evt | input | 32 | Event strobes, channel c at bits 8c+7..8c |
| phy_sync_err | input | 5 | Escape sync error group (level) |
| phy_esc_err | input | 5 | Escape error group (edge) |
| phy_ctrl_err | input | 5 | Control error group (level) |
| phy_lp0_cont | input | 5 | LP0 contention group (level) |
| phy_lp1_cont | input | 5 | LP1 contention group (level) |
| disp_irq | input | 1 | Interrupt from the display controller |
| link_irq | output | 1 | Registered link-engine interrupt |
| subsys_irq | output | 1 | Combined subsystem interrupt |

## Verification
The bound checker watches several properties on every cycle. A switched-off channel's clear flags stay clear, and no flag is lost without a clearing write. A gated event always ends up in its flag, even when a clear arrives with it. A rising `link_irq` always has a cause in the previous cycle, and enabled level or edge errors always reach the physical-layer flag. Other behaviour can only be shown by the bench's sweeps, because those checks need expected values computed from stimulus history. That covers the exact register readback, the pending summary under every mask/channel-enable combination, the fact that a held escape error does not re-trigger, and the OR with the controller interrupt.

// File: rtl/vc_irq_pkg.sv
package vc_irq_pkg;
    localparam int unsigned DATA_W        = 32;
    localparam int unsigned DEF_NUM_CH    = 4;
    localparam int unsigned DEF_EVT_W     = 8;
    localparam int unsigned DEF_GRP_W     = 5;
    localparam int unsigned REG_CHAN_ON   = 0;
    localparam int unsigned REG_IRQ_EN    = 1;
    localparam int unsigned REG_IRQ_STAT  = 2;
    localparam int unsigned REG_MASK_BASE = 4;
endpackage

// File: rtl/phy_err_detect.sv
module phy_err_detect #(
    parameter int unsigned GRP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GRP_W-1:0] sync_err,
    input  logic [GRP_W-1:0] esc_err,
    input  logic [GRP_W-1:0] ctrl_err,
    input  logic [GRP_W-1:0] lp0_cont,
    input  logic [GRP_W-1:0] lp1_cont,
    output logic             err_hit
);
    typedef struct packed {
        logic [GRP_W-1:0] esc_prev;
    } det_t;

    det_t det_d, det_q;
    logic level_hit;
    logic edge_hit;

    always_comb begin
        det_d          = det_q;
        det_d.esc_prev = esc_err;
        level_hit      = |{sync_err, ctrl_err, lp0_cont, lp1_cont};
        edge_hit       = |(esc_err & ~det_q.esc_prev);
        err_hit        = level_hit | edge_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end
endmodule

// File: rtl/vc_flag_bank.sv
module vc_flag_bank #(
    parameter int unsigned EVT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ch_on,
    input  logic [EVT_W-1:0] evt,
    input  logic [EVT_W-1:0] clr,
    input  logic [EVT_W-1:0] mask,
    output logic [EVT_W-1:0] flags,
    output logic             pending
);
    typedef struct packed {
        logic [EVT_W-1:0] flags;
    } bank_t;

    bank_t bank_d, bank_q;

    // set wins over clear: the OR of the new events is applied last
    always_comb begin
        bank_d       = bank_q;
        bank_d.flags = (bank_q.flags & ~clr) | (ch_on ? evt : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign flags   = bank_q.flags;
    assign pending = |(bank_q.flags & mask);
endmodule

// File: rtl/vc_irq_merge.sv
module vc_irq_merge
    import vc_irq_pkg::*;
#(
    parameter int unsigned NUM_CH = DEF_NUM_CH,
    parameter int unsigned EVT_W  = DEF_EVT_W,
    parameter int unsigned GRP_W  = DEF_GRP_W,
    localparam int unsigned FLAG_BASE = REG_MASK_BASE + NUM_CH,
    localparam int unsigned AW        = $clog2(FLAG_BASE + NUM_CH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [AW-1:0]           reg_addr,
    input  logic [DATA_W-1:0]       reg_wdata,
    output logic [DATA_W-1:0]       reg_rdata,
    input  logic [NUM_CH*EVT_W-1:0] vc_evt,
    input  logic [GRP_W-1:0]        phy_sync_err,
    input  logic [GRP_W-1:0]        phy_esc_err,
    input  logic [GRP_W-1:0]        phy_ctrl_err,
    input  logic [GRP_W-1:0]        phy_lp0_cont,
    input  logic [GRP_W-1:0]        phy_lp1_cont,
    input  logic                    disp_irq,
    output logic                    link_irq,
    output logic                    subsys_irq
);
    localparam int unsigned USED_W = (EVT_W > NUM_CH + 1) ? EVT_W : NUM_CH + 1;

    typedef struct packed {
        logic [NUM_CH-1:0]            chan_on;
        logic [NUM_CH:0]              irq_en;
        logic [NUM_CH-1:0][EVT_W-1:0] mask;
        logic                         phy_stat;
        logic                         link_irq;
    } regs_t;

    regs_t                   reg_d, reg_q;
    logic [NUM_CH*EVT_W-1:0] flag_all;
    logic [NUM_CH*EVT_W-1:0] clr_all;
    logic [NUM_CH*EVT_W-1:0] mask_all;
    logic [NUM_CH-1:0]       pend;
    logic [NUM_CH:0]         glb_stat;
    logic                    clr_phy;
    logic                    phy_hit;
    logic                    unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:USED_W];
    assign mask_all     = reg_q.mask;
    assign glb_stat     = {reg_q.phy_stat, pend};

    phy_err_detect #(.GRP_W(GRP_W)) u_phy (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_err (phy_sync_err),
        .esc_err  (phy_esc_err),
        .ctrl_err (phy_ctrl_err),
        .lp0_cont (phy_lp0_cont),
        .lp1_cont (phy_lp1_cont),
        .err_hit  (phy_hit)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_bank
        vc_flag_bank #(.EVT_W(EVT_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .ch_on   (reg_q.chan_on[g]),
            .evt     (vc_evt[g*EVT_W +: EVT_W]),
            .clr     (clr_all[g*EVT_W +: EVT_W]),
            .mask    (reg_q.mask[g]),
            .flags   (flag_all[g*EVT_W +: EVT_W]),
            .pending (pend[g])
        );
    end

    // write-one-to-clear strobes
    always_comb begin
        clr_all = '0;
        clr_phy = reg_wr && (reg_addr == AW'(REG_IRQ_STAT)) && reg_wdata[NUM_CH];
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (reg_wr && (reg_addr == AW'(FLAG_BASE + ch)))
                clr_all[ch*EVT_W +: EVT_W] = reg_wdata[EVT_W-1:0];
        end
    end

    // next-state of configuration, error flag and interrupt
    always_comb begin
        reg_d = reg_q;
        if (reg_wr) begin
            if (reg_addr == AW'(REG_CHAN_ON)) reg_d.chan_on = reg_wdata[NUM_CH-1:0];
            if (reg_addr == AW'(REG_IRQ_EN))  reg_d.irq_en  = reg_wdata[NUM_CH:0];
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (reg_addr == AW'(REG_MASK_BASE + ch)) reg_d.mask[ch] = reg_wdata[EVT_W-1:0];
            end
        end
        reg_d.phy_stat = (reg_q.phy_stat & ~clr_phy) | (phy_hit & reg_q.irq_en[NUM_CH]);
        reg_d.link_irq = |(glb_stat & reg_q.irq_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(REG_CHAN_ON))  reg_rdata = DATA_W'(reg_q.chan_on);
        if (reg_addr == AW'(REG_IRQ_EN))   reg_rdata = DATA_W'(reg_q.irq_en);
        if (reg_addr == AW'(REG_IRQ_STAT)) reg_rdata = DATA_W'(glb_stat);
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (reg_addr == AW'(REG_MASK_BASE + ch)) reg_rdata = DATA_W'(reg_q.mask[ch]);
            if (reg_addr == AW'(FLAG_BASE + ch))     reg_rdata = DATA_W'(flag_all[ch*EVT_W +: EVT_W]);
        end
    end

    assign link_irq   = reg_q.link_irq;
    assign subsys_irq = reg_q.link_irq | disp_irq;
endmodule

// File: rtl/vc_irq_merge_chk.sv
module vc_irq_merge_chk #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned EVT_W  = 8,
    parameter int unsigned GRP_W  = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_CH-1:0]       chan_on,
    input logic [NUM_CH:0]         irq_en,
    input logic [NUM_CH*EVT_W-1:0] mask_all,
    input logic [NUM_CH*EVT_W-1:0] flag_all,
    input logic [NUM_CH*EVT_W-1:0] clr_all,
    input logic [NUM_CH*EVT_W-1:0] vc_evt,
    input logic [GRP_W-1:0]        sync_err,
    input logic [GRP_W-1:0]        esc_err,
    input logic [GRP_W-1:0]        ctrl_err,
    input logic [GRP_W-1:0]        lp0_cont,
    input logic [GRP_W-1:0]        lp1_cont,
    input logic                    phy_stat,
    input logic                    link_irq
);
    logic [NUM_CH*EVT_W-1:0] gated_evt;
    logic [NUM_CH-1:0]       summ;
    logic                    cause;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign gated_evt[g*EVT_W +: EVT_W] = chan_on[g] ? vc_evt[g*EVT_W +: EVT_W] : '0;
        assign summ[g] = |(flag_all[g*EVT_W +: EVT_W] & mask_all[g*EVT_W +: EVT_W]);

        assert_off_channel_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!chan_on[g] && flag_all[g*EVT_W +: EVT_W] == '0) |=> flag_all[g*EVT_W +: EVT_W] == '0);
    end

    assign cause = |(summ & irq_en[NUM_CH-1:0]) | (phy_stat & irq_en[NUM_CH]);

    assert_flags_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(flag_all) & ~$past(clr_all) & ~flag_all) == '0));

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(gated_evt) & ~flag_all) == '0));

    assert_irq_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_irq) |-> $past(cause));

    assert_level_err_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|{sync_err, ctrl_err, lp0_cont, lp1_cont}) && irq_en[NUM_CH]) |=> phy_stat);

    assert_esc_edge_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(esc_err & ~$past(esc_err))) && irq_en[NUM_CH]) |=> phy_stat);
endmodule

bind vc_irq_merge vc_irq_merge_chk #(
    .NUM_CH(NUM_CH),
    .EVT_W (EVT_W),
    .GRP_W (GRP_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_on  (reg_q.chan_on),
    .irq_en   (reg_q.irq_en),
    .mask_all (mask_all),
    .flag_all (flag_all),
    .clr_all  (clr_all),
    .vc_evt   (vc_evt),
    .sync_err (phy_sync_err),
    .esc_err  (phy_esc_err),
    .ctrl_err (phy_ctrl_err),
    .lp0_cont (phy_lp0_cont),
    .lp1_cont (phy_lp1_cont),
    .phy_stat (reg_q.phy_stat),
    .link_irq (link_irq)
);

// File: tb/tb_vc_irq_merge.sv
module tb_vc_irq_merge;
    localparam int NUM_CH = 4;
    localparam int EVT_W  = 8;
    localparam int GRP_W  = 5;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    reg_wr = 1'b0;
    logic [3:0]              reg_addr = '0;
    logic [31:0]             reg_wdata = '0;
    logic [31:0]             reg_rdata;
    logic [NUM_CH*EVT_W-1:0] vc_evt = '0;
    logic [GRP_W-1:0]        phy_sync_err = '0;
    logic [GRP_W-1:0]        phy_esc_err = '0;
    logic [GRP_W-1:0]        phy_ctrl_err = '0;
    logic [GRP_W-1:0]        phy_lp0_cont = '0;
    logic [GRP_W-1:0]        phy_lp1_cont = '0;
    logic                    disp_irq = 1'b0;
    logic                    link_irq;
    logic                    subsys_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vc_irq_merge dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vc_evt(vc_evt),
        .phy_sync_err(phy_sync_err), .phy_esc_err(phy_esc_err),
        .phy_ctrl_err(phy_ctrl_err), .phy_lp0_cont(phy_lp0_cont),
        .phy_lp1_cont(phy_lp1_cont), .disp_irq(disp_irq),
        .link_irq(link_irq), .subsys_irq(subsys_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 32'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = 4'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic set_level(input int g, input logic [GRP_W-1:0] v);
        case (g)
            0: phy_sync_err = v;
            1: phy_ctrl_err = v;
            2: phy_lp0_cont = v;
            default: phy_lp1_cont = v;
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 12; a++) begin
            rd(a, v); chk("R1 reg reset", v, 0);
        end
        chk("R1 link_irq reset", link_irq, 0);
        chk("R1 subsys_irq reset", subsys_irq, 0);

        // R2 R3 R5 R6 sweep over channel, bit, channel on, mask bit
        for (int ch = 0; ch < NUM_CH; ch++) begin
            for (int b = 0; b < EVT_W; b++) begin
                for (int on = 0; on < 2; on++) begin
                    for (int m = 0; m < 2; m++) begin
                        wr(0, on << ch);
                        wr(4 + ch, m << b);
                        wr(1, 1 << ch);
                        vc_evt[ch*EVT_W + b] = 1'b1;
                        @(negedge clk);
                        vc_evt = '0;
                        rd(8 + ch, v); chk("R2 flag latch", v, on << b);
                        rd(2, v);      chk("R5 summary", v, (on & m) << ch);
                        chk("R6 irq registered late", link_irq, 0);
                        @(negedge clk);
                        chk("R6 irq asserted", link_irq, on & m);
                        if (on == 1) begin
                            wr(8 + ch, 0);
                            rd(8 + ch, v); chk("R3 write zero keeps flag", v, 1 << b);
                            wr(8 + ch, 1 << b);
                            rd(8 + ch, v); chk("R3 w1c clears flag", v, 0);
                            @(negedge clk);
                            chk("R6 irq released", link_irq, 0);
                        end
                    end
                end
            end
        end

        // R6 global enable gating
        wr(0, 4'b0010); wr(5, 8'hFF); wr(1, 0);
        vc_evt[EVT_W + 6] = 1'b1;
        @(negedge clk); vc_evt = '0;
        rd(2, v); chk("R5 summary without enable", v, 32'h2);
        repeat (2) @(negedge clk);
        chk("R6 irq masked by enable", link_irq, 0);
        wr(1, 32'h2);
        @(negedge clk);
        chk("R6 irq after enable", link_irq, 1);
        wr(9, 8'hFF);
        @(negedge clk);
        chk("R6 irq after clear", link_irq, 0);

        // R4 set beats clear
        wr(0, 4'b0100);
        vc_evt[2*EVT_W + 3] = 1'b1; vc_evt[2*EVT_W + 5] = 1'b1;
        @(negedge clk); vc_evt = '0;
        rd(10, v); chk("R4 setup", v, 32'h28);
        @(negedge clk);
        vc_evt[2*EVT_W + 3] = 1'b1;
        reg_wr = 1'b1; reg_addr = 4'd10; reg_wdata = 32'h28;
        @(negedge clk);
        reg_wr = 1'b0; vc_evt = '0;
        rd(10, v); chk("R4 set wins over clear", v, 32'h08);
        wr(10, 8'hFF);

        // R10 readback
        wr(0, 32'hFFFF_FFFA); rd(0, v); chk("R10 chan_on readback", v, 32'hA);
        wr(1, 32'hFFFF_FFF5); rd(1, v); chk("R10 irq_en readback", v, 32'h15);
        for (int c = 0; c < NUM_CH; c++) wr(4 + c, 32'hABCD_0000 | (8'hC3 ^ c));
        for (int c = 0; c < NUM_CH; c++) begin
            rd(4 + c, v); chk("R10 mask readback", v, 8'hC3 ^ c);
        end
        wr(0, 0); wr(1, 0);
        for (int c = 0; c < NUM_CH; c++) wr(4 + c, 0);

        // R7 level groups, enabled
        wr(1, 32'h10);
        for (int g = 0; g < 4; g++) begin
            for (int b = 0; b < GRP_W; b++) begin
                @(negedge clk);
                set_level(g, GRP_W'(1 << b));
                @(negedge clk);
                set_level(g, '0);
                rd(2, v); chk("R7 level error sets", v, 32'h10);
                @(negedge clk);
                chk("R6 phy irq", link_irq, 1);
                wr(2, 32'h10);
                rd(2, v); chk("R7 phy w1c", v, 0);
                @(negedge clk);
                chk("R6 phy irq released", link_irq, 0);
            end
        end

        // R7 level groups, disabled
        wr(1, 0);
        for (int g = 0; g < 4; g++) begin
            @(negedge clk);
            set_level(g, '1);
            @(negedge clk);
            set_level(g, '0);
            rd(2, v); chk("R7 disabled error ignored", v, 0);
        end
        chk("R7 no irq when disabled", link_irq, 0);

        // R8 escape group edge behaviour
        wr(1, 32'h10);
        for (int b = 0; b < GRP_W; b++) begin
            @(negedge clk);
            phy_esc_err[b] = 1'b1;
            @(negedge clk);
            rd(2, v); chk("R8 rising edge sets", v, 32'h10);
            wr(2, 32'h10);
            repeat (3) @(negedge clk);
            rd(2, v); chk("R8 held level ignored", v, 0);
            phy_esc_err = '0;
            repeat (2) @(negedge clk);
            rd(2, v); chk("R8 falling edge ignored", v, 0);
        end

        // R9 merge with controller interrupt
        disp_irq = 1'b1; #1;
        chk("R9 disp only", subsys_irq, 1);
        disp_irq = 1'b0; #1;
        chk("R9 none", subsys_irq, 0);
        @(negedge clk);
        phy_lp1_cont = 5'h10;
        @(negedge clk);
        phy_lp1_cont = '0;
        @(negedge clk);
        chk("R9 link only", subsys_irq, 1);
        disp_irq = 1'b1; #1;
        chk("R9 both", subsys_irq, 1);
        disp_irq = 1'b0;
        wr(2, 32'h10);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule